// File: doc/BRIEF.md
# Limited-Pointer Directory Entry

This block is the sharer-tracking logic of one directory entry in a coherence controller. Instead of one presence bit per node, it records up to `PTRS` sharers as node numbers of `log2(NODES)` bits each, plus an overflow flag. Requests arrive one per cycle as a two-bit operation code and a node number: add a sharer, remove a sharer, or write by a node.

On a write, and on an add that displaces a sharer, the block emits a one-cycle strobe with an `NODES`-bit mask of the nodes that must be invalidated. The elaboration parameter `POLICY` selects what happens when a new sharer arrives and every pointer is already in use. Broadcast mode sets the overflow flag, and a later write then hits every node. Evicting mode pushes out the oldest sharer. Coarse mode reuses the pointer bits as a vector in which each bit covers a group of nodes.

Memory data, network messages and acknowledgement counting are handled elsewhere.

Top module: `lptr_dir_entry`

## Requirements
- R1: After synchronous active-low reset, `inv_valid` is 0, `inv_mask` is zero and the entry holds no sharers. A write as the first operation therefore strobes an all-zero mask.
- R2: `op_code` encoding: 0 = idle, 1 = add sharer, 2 = remove sharer, 3 = write. Idle changes nothing and raises no strobe.
- R3: In normal mode, adding a node that is already recorded leaves the entry unchanged. Adding a new node while a pointer is free records it. The number of recorded pointers never exceeds `PTRS`.
- R4: In normal mode, removing a recorded node deletes it and removing an absent node has no effect. Once the overflow flag is set, removes are ignored.
- R5: A write at edge t gives `inv_valid`=1 for the one cycle after t. `inv_mask` then holds the current sharer set with the writer's bit cleared. The strobe occurs even when the mask is empty.
- R6: After a write, the entry is in normal mode and holds only the writer.
- R7: With the broadcast policy, adding a new node while all `PTRS` pointers are in use sets overflow. Later adds change nothing, and the next write invalidates every node except the writer.
- R8: With the evicting policy, adding a new node to a full entry replaces the oldest recorded sharer (first-in first-out). One cycle later, a strobe carries only the displaced node's bit. Overflow never occurs under this policy.
- R9: With the coarse policy, overflow turns the `PTRS*log2(NODES)` storage bits into a vector. Node n maps to bit n/G, where G = ceil(NODES/(PTRS*log2(NODES))). On overflow the groups of the existing sharers and of the new node are marked, and later adds mark their group. A write invalidates every node in a marked group except the writer. For 16 nodes and 2 pointers the vector has 8 bits and G = 2.
- R10: `inv_valid` rises only after a write, or after an add that evicts under the evicting policy. `inv_mask` is zero whenever `inv_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 2 | Operation: 0 idle, 1 add, 2 remove, 3 write |
| op_node | input | log2(NODES) | Node the operation refers to |
| inv_valid | output | 1 | One-cycle strobe qualifying `inv_mask` |
| inv_mask | output | NODES | Nodes to invalidate, one bit per node |

## Verification
A corrupted pointer, count or overflow flag inside the entry stays hidden until the next write or evicting add. That operation then shows a wrong `inv_mask` in the cycle right after it. The bench therefore issues a write often enough that no stored state survives long without being exposed. It sweeps a long pseudo-random operation stream over all sixteen nodes against all three policies in parallel, so every overflow path is reached many times. Each mask is compared with a set-based model of the sharers, kept separately from the pointer representation.

// File: rtl/lptr_dir_pkg.sv
// Shared types for the limited-pointer directory entry.
// Assumes nothing beyond a two-bit operation field on the request side.
package lptr_dir_pkg;

    // Request operation codes; values are visible at the port op_code.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_ADD  = 2'd1,
        OP_REM  = 2'd2,
        OP_WR   = 2'd3
    } dir_op_e;

    // Representation chosen when a new sharer finds every pointer in use.
    typedef enum logic [1:0] {
        POL_BCAST  = 2'd0,
        POL_EVICT  = 2'd1,
        POL_COARSE = 2'd2
    } ovf_policy_e;

endpackage

// File: rtl/lptr_dir_expand.sv
// Turns the stored entry into a NODES-bit sharer set.
// In normal mode the first cnt pointers are decoded; in overflow mode the
// policy picks the reading of the storage bits. Assumes NODES is a power of
// two and PTRS*log2(NODES) >= 2.
module lptr_dir_expand
    import lptr_dir_pkg::*;
#(
    parameter int          NODES  = 16,
    parameter int          PTRS   = 2,
    parameter ovf_policy_e POLICY = POL_COARSE,
    localparam int NW  = $clog2(NODES),
    localparam int SW  = PTRS * NW,
    localparam int CW  = $clog2(PTRS + 1),
    localparam int GRP = (NODES + SW - 1) / SW
) (
    input  logic [SW-1:0]    store,
    input  logic [CW-1:0]    cnt,
    input  logic             ovf,
    output logic [NODES-1:0] sharers
);

    logic [NODES-1:0] ptr_map;
    logic [NODES-1:0] ovf_map;

    // Decode every live pointer into its node bit.
    always_comb begin
        ptr_map = '0;
        for (int j = 0; j < PTRS; j++) begin
            if (CW'(j) < cnt) ptr_map[store[j*NW +: NW]] = 1'b1;
        end
    end

    // Overflow reading of the storage, selected by policy.
    generate
        if (POLICY == POL_BCAST) begin : g_bcast
            assign ovf_map = '1;
        end else if (POLICY == POL_COARSE) begin : g_coarse
            for (genvar n = 0; n < NODES; n++) begin : g_node
                assign ovf_map[n] = store[n / GRP];
            end
        end else begin : g_evict
            assign ovf_map = '0;
        end
    endgenerate

    // Pick the reading that matches the current mode.
    assign sharers = ovf ? ovf_map : ptr_map;

endmodule

// File: rtl/lptr_dir_update.sv
// Next-state and invalidation logic for one directory entry.
// Live pointers occupy slots 0..cnt-1 in arrival order (slot 0 oldest).
// Assumes the same geometry constraints as lptr_dir_expand.
module lptr_dir_update
    import lptr_dir_pkg::*;
#(
    parameter int          NODES  = 16,
    parameter int          PTRS   = 2,
    parameter ovf_policy_e POLICY = POL_COARSE,
    localparam int NW  = $clog2(NODES),
    localparam int SW  = PTRS * NW,
    localparam int CW  = $clog2(PTRS + 1),
    localparam int GRP = (NODES + SW - 1) / SW,
    localparam int GIW = (SW > 1) ? $clog2(SW) : 1
) (
    input  dir_op_e          op,
    input  logic [NW-1:0]    node,
    input  logic [SW-1:0]    store,
    input  logic [CW-1:0]    cnt,
    input  logic             ovf,
    input  logic [NODES-1:0] sharers,
    output logic [SW-1:0]    store_n,
    output logic [CW-1:0]    cnt_n,
    output logic             ovf_n,
    output logic             fire,
    output logic [NODES-1:0] fire_mask
);

    logic [NW-1:0] ptr_c [PTRS];
    logic [NW-1:0] ptr_n [PTRS];
    logic [SW-1:0] ptr_pack;
    logic [SW-1:0] cv_n;
    logic          use_cv;
    logic          hit;
    logic [CW-1:0] hit_idx;

    // Coarse-vector bit that covers a node.
    function automatic logic [GIW-1:0] grp_of(input logic [NW-1:0] n);
        return GIW'(32'(n) / GRP);
    endfunction

    // Split and rejoin the flat storage as pointer slots.
    generate
        for (genvar g = 0; g < PTRS; g++) begin : g_slot
            assign ptr_c[g]               = store[g*NW +: NW];
            assign ptr_pack[g*NW +: NW]   = ptr_n[g];
        end
    endgenerate

    // Find the first live pointer naming the request node.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int j = 0; j < PTRS; j++) begin
            if (!hit && CW'(j) < cnt && ptr_c[j] == node) begin
                hit     = 1'b1;
                hit_idx = CW'(j);
            end
        end
    end

    // Apply the request to the entry and form any invalidation set.
    always_comb begin
        ptr_n     = ptr_c;
        cnt_n     = cnt;
        ovf_n     = ovf;
        cv_n      = store;
        use_cv    = 1'b0;
        fire      = 1'b0;
        fire_mask = '0;
        case (op)
            OP_ADD: begin
                if (ovf) begin
                    if (POLICY == POL_COARSE) begin
                        use_cv             = 1'b1;
                        cv_n[grp_of(node)] = 1'b1;
                    end
                end else if (!hit) begin
                    if (cnt < CW'(PTRS)) begin
                        ptr_n[cnt] = node;
                        cnt_n      = cnt + CW'(1);
                    end else if (POLICY == POL_EVICT) begin
                        fire                = 1'b1;
                        fire_mask[ptr_c[0]] = 1'b1;
                        for (int j = 0; j < PTRS - 1; j++) ptr_n[j] = ptr_c[j+1];
                        ptr_n[PTRS-1] = node;
                    end else begin
                        ovf_n = 1'b1;
                        if (POLICY == POL_COARSE) begin
                            use_cv = 1'b1;
                            cv_n   = '0;
                            for (int j = 0; j < PTRS; j++) cv_n[grp_of(ptr_c[j])] = 1'b1;
                            cv_n[grp_of(node)] = 1'b1;
                        end
                    end
                end
            end
            OP_REM: begin
                if (!ovf && hit) begin
                    for (int j = 0; j < PTRS - 1; j++) begin
                        if (CW'(j) >= hit_idx) ptr_n[j] = ptr_c[j+1];
                    end
                    ptr_n[PTRS-1] = '0;
                    cnt_n         = cnt - CW'(1);
                end
            end
            OP_WR: begin
                fire            = 1'b1;
                fire_mask       = sharers;
                fire_mask[node] = 1'b0;
                for (int j = 0; j < PTRS; j++) ptr_n[j] = '0;
                ptr_n[0] = node;
                cnt_n    = CW'(1);
                ovf_n    = 1'b0;
            end
            default: ;
        endcase
    end

    // Coarse rewrites replace the whole storage; otherwise repack slots.
    assign store_n = use_cv ? cv_n : ptr_pack;

endmodule

// File: rtl/lptr_dir_entry.sv
// One limited-pointer directory entry with a selectable overflow policy.
// Accepts one operation per cycle; the invalidation strobe and mask are
// registered and appear the cycle after the operation that causes them.
// Assumes NODES is a power of two and PTRS*log2(NODES) >= 2.
module lptr_dir_entry
    import lptr_dir_pkg::*;
#(
    parameter int          NODES  = 16,
    parameter int          PTRS   = 2,
    parameter ovf_policy_e POLICY = POL_COARSE,
    localparam int NW = $clog2(NODES),
    localparam int SW = PTRS * NW,
    localparam int CW = $clog2(PTRS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_code,
    input  logic [NW-1:0]    op_node,
    output logic             inv_valid,
    output logic [NODES-1:0] inv_mask
);

    logic [SW-1:0]    store_q, store_n;
    logic [CW-1:0]    cnt_q, cnt_n;
    logic             ovf_q, ovf_n;
    logic [NODES-1:0] sharers;
    logic             fire;
    logic [NODES-1:0] fire_mask;

    lptr_dir_expand #(.NODES(NODES), .PTRS(PTRS), .POLICY(POLICY)) u_expand (
        .store   (store_q),
        .cnt     (cnt_q),
        .ovf     (ovf_q),
        .sharers (sharers)
    );

    lptr_dir_update #(.NODES(NODES), .PTRS(PTRS), .POLICY(POLICY)) u_update (
        .op        (dir_op_e'(op_code)),
        .node      (op_node),
        .store     (store_q),
        .cnt       (cnt_q),
        .ovf       (ovf_q),
        .sharers   (sharers),
        .store_n   (store_n),
        .cnt_n     (cnt_n),
        .ovf_n     (ovf_n),
        .fire      (fire),
        .fire_mask (fire_mask)
    );

    // Entry state and registered invalidation output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q   <= '0;
            cnt_q     <= '0;
            ovf_q     <= 1'b0;
            inv_valid <= 1'b0;
            inv_mask  <= '0;
        end else begin
            store_q   <= store_n;
            cnt_q     <= cnt_n;
            ovf_q     <= ovf_n;
            inv_valid <= fire;
            inv_mask  <= fire ? fire_mask : '0;
        end
    end

endmodule

// File: rtl/lptr_dir_chk.sv
// Protocol checks for lptr_dir_entry, attached by bind below.
// Observes the ports plus the pointer count and overflow flag.
module lptr_dir_chk
    import lptr_dir_pkg::*;
#(
    parameter int          NODES  = 16,
    parameter int          PTRS   = 2,
    parameter ovf_policy_e POLICY = POL_COARSE,
    localparam int NW = $clog2(NODES),
    localparam int CW = $clog2(PTRS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_code,
    input logic [NW-1:0]    op_node,
    input logic             inv_valid,
    input logic [NODES-1:0] inv_mask,
    input logic             ovf_q,
    input logic [CW-1:0]    cnt_q
);

    // R10
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(rst_n) && ($past(op_code) == 2'd3 ||
                      ($past(op_code) == 2'd1 && POLICY == POL_EVICT)));

    // R10
    quiet_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |-> inv_mask == '0);

    // R5
    writer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == 2'd3) |-> inv_valid && !inv_mask[$past(op_node)]);

    // R6
    post_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == 2'd3) |-> !ovf_q && cnt_q == CW'(1));

    // R8
    evict_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && $past(rst_n) && $past(op_code) == 2'd1) |-> $countones(inv_mask) == 1);

    // R3
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PTRS));

endmodule

bind lptr_dir_entry lptr_dir_chk #(.NODES(NODES), .PTRS(PTRS), .POLICY(POLICY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .op_node   (op_node),
    .inv_valid (inv_valid),
    .inv_mask  (inv_mask),
    .ovf_q     (ovf_q),
    .cnt_q     (cnt_q)
);

// File: tb/lptr_dir_entry_bench.sv
// Drives all three overflow policies with one operation stream and checks
// each output against set-based models kept in the bench.
module lptr_dir_entry_bench;
    import lptr_dir_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int P  = 2;
    localparam int NW = $clog2(N);
    localparam int G  = (N + P * NW - 1) / (P * NW);
    localparam int SWEEP = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op_code = 2'd0;
    logic [NW-1:0] op_node = '0;
    logic          iv [3];
    logic [N-1:0]  im [3];
    logic          v_bc, v_ev, v_cv;
    logic [N-1:0]  m_bc, m_ev, m_cv;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // Model state: index 0 broadcast, 1 evicting, 2 coarse.
    logic [N-1:0] ex [3];
    logic         om [3];
    int           q [P];
    int           qn;
    logic         ev_v [3];
    logic [N-1:0] ev_m [3];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lptr_dir_entry #(.NODES(N), .PTRS(P), .POLICY(POL_BCAST)) u_lptr_dir_entry_bc (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_node(op_node),
        .inv_valid(v_bc), .inv_mask(m_bc));
    lptr_dir_entry #(.NODES(N), .PTRS(P), .POLICY(POL_EVICT)) u_lptr_dir_entry_ev (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_node(op_node),
        .inv_valid(v_ev), .inv_mask(m_ev));
    lptr_dir_entry #(.NODES(N), .PTRS(P), .POLICY(POL_COARSE)) u_lptr_dir_entry (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_node(op_node),
        .inv_valid(v_cv), .inv_mask(m_cv));

    assign iv[0] = v_bc; assign iv[1] = v_ev; assign iv[2] = v_cv;
    assign im[0] = m_bc; assign im[1] = m_ev; assign im[2] = m_cv;

    // One comparison; prints FAIL with requirement, actual and expected.
    task automatic chk(input bit ok, input string tag, input logic [N:0] act, input logic [N:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Group expansion for the coarse policy: node n marked if any node of its group is.
    function automatic logic [N-1:0] gexp(input logic [N-1:0] s);
        logic [N-1:0] r = '0;
        for (int n = 0; n < N; n++)
            for (int m = 0; m < N; m++)
                if (s[m] && (m / G) == (n / G)) r[n] = 1'b1;
        return r;
    endfunction

    // Advance the models by one operation and set expected outputs.
    task automatic model(input logic [1:0] op, input int n);
        for (int p = 0; p < 3; p++) begin ev_v[p] = 1'b0; ev_m[p] = '0; end
        for (int p = 0; p < 3; p += 2) begin
            case (op)
                2'd1: if (om[p]) ex[p][n] = 1'b1;
                      else if (!ex[p][n]) begin
                          if ($countones(ex[p]) >= P) om[p] = 1'b1;
                          ex[p][n] = 1'b1;
                      end
                2'd2: if (!om[p]) ex[p][n] = 1'b0;
                2'd3: begin
                    ev_v[p] = 1'b1;
                    ev_m[p] = !om[p] ? ex[p] : (p == 0 ? {N{1'b1}} : gexp(ex[p]));
                    ev_m[p][n] = 1'b0;
                    ex[p] = '0; ex[p][n] = 1'b1; om[p] = 1'b0;
                end
                default: ;
            endcase
        end
        case (op)
            2'd1: begin
                bit found = 1'b0;
                for (int k = 0; k < qn; k++) if (q[k] == n) found = 1'b1;
                if (!found) begin
                    if (qn < P) begin q[qn] = n; qn++; end
                    else begin
                        ev_v[1] = 1'b1; ev_m[1][q[0]] = 1'b1;
                        for (int k = 0; k < P - 1; k++) q[k] = q[k+1];
                        q[P-1] = n;
                    end
                end
            end
            2'd2: begin
                int at = -1;
                for (int k = 0; k < qn; k++) if (at < 0 && q[k] == n) at = k;
                if (at >= 0) begin
                    for (int k = at; k < qn - 1; k++) q[k] = q[k+1];
                    qn--;
                end
            end
            2'd3: begin
                ev_v[1] = 1'b1;
                for (int k = 0; k < qn; k++) ev_m[1][q[k]] = 1'b1;
                ev_m[1][n] = 1'b0;
                q[0] = n; qn = 1;
            end
            default: ;
        endcase
    endtask

    // Apply one operation, then compare every policy one cycle later.
    task automatic step(input logic [1:0] op, input int n);
        string tag;
        @(negedge clk);
        op_code = op;
        op_node = NW'(n);
        model(op, n);
        @(posedge clk);
        #1;
        case (op)
            2'd1: tag = "R3 R7 R8 R9 add";
            2'd2: tag = "R4 remove";
            2'd3: tag = "R5 R6 R7 R9 write";
            default: tag = "R2 R10 idle";
        endcase
        for (int p = 0; p < 3; p++)
            chk(iv[p] == ev_v[p] && im[p] == ev_m[p], tag, {iv[p], im[p]}, {ev_v[p], ev_m[p]});
    endtask

    initial begin
        logic [31:0] lf = 32'hACE1_2468;
        for (int p = 0; p < 3; p++) begin ex[p] = '0; om[p] = 1'b0; end
        qn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int p = 0; p < 3; p++) chk(!iv[p] && im[p] == '0, "R1 reset", {iv[p], im[p]}, '0);

        // Directed overflow: sharers 3, 5, then 9 overflows two pointers.
        step(2'd1, 3);
        step(2'd1, 5);
        step(2'd1, 9);
        chk(v_ev && m_ev == 16'h0008, "R8 evict oldest", {v_ev, m_ev}, {1'b1, 16'h0008});
        chk(!v_bc && !v_cv, "R10 no strobe on overflow", {v_bc, m_bc}, '0);
        step(2'd2, 3);
        step(2'd3, 0);
        chk(m_bc == 16'hFFFE, "R7 broadcast write", {v_bc, m_bc}, {1'b1, 16'hFFFE});
        chk(m_ev == 16'h0220, "R8 survivors", {v_ev, m_ev}, {1'b1, 16'h0220});
        chk(m_cv == 16'h033C, "R9 R4 coarse groups", {v_cv, m_cv}, {1'b1, 16'h033C});
        step(2'd3, 7);
        chk(m_bc == 16'h0001 && m_cv == 16'h0001, "R6 only writer left", {v_cv, m_cv}, {1'b1, 16'h0001});
        step(2'd1, 7);
        step(2'd1, 4);
        step(2'd2, 4);
        step(2'd0, 2);
        step(2'd3, 7);
        chk(v_ev && m_ev == '0, "R3 R4 R5 empty strobe", {v_ev, m_ev}, {1'b1, 16'h0000});

        // Pseudo-random sweep over all nodes and operations.
        for (int i = 0; i < SWEEP; i++) begin
            logic [1:0] op;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case (lf[2:0])
                3'd4: op = 2'd2;
                3'd5: op = 2'd3;
                3'd6: op = 2'd0;
                default: op = 2'd1;
            endcase
            step(op, int'(lf[7:4]));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule